// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Interface

This block is a parallel bus slave. It lets an external microprocessor read and write a small bank of 8-bit registers over an 8-bit address bus and an 8-bit data bus. The data bus appears at the block edge as a separate input, output and drive-enable. One static pin chooses the strobe protocol. In split-strobe mode there is an active-low read strobe and an active-low write strobe. In enable-strobe mode there is a read/write level and a high-active enable. The two protocols share two pins: `rd_n_e` and `wr_n_rw`.

Every host-side control is asynchronous to the block's clock. Each one passes through a two-flop synchronizer. Address and data are delayed through matching pipelines, so the sampled values line up with the strobe edge that commits them.

An access state machine tracks each transfer. Its states are IDLE, READ, WR_HOLD and COMMIT, and its transitions are:

- IDLE→READ: a read level is seen.
- IDLE→WR_HOLD: a write level is seen.
- READ→IDLE: the read level is gone.
- WR_HOLD→COMMIT: a qualifying commit edge.
- WR_HOLD→IDLE: abort, because the write level was lost without a qualifying edge.
- COMMIT→IDLE: always, after one cycle.

COMMIT lasts exactly one clock and is the only write pulse into the register bank.

An address strobe supports multiplexed buses. While it is high the address passes through. Its falling edge freezes the address until it rises again.

An interrupt status register collects one-clock pulses from internal sources, and a mask register enables them. The interrupt pin is pulled low whenever any enabled status bit is set. An active-low output enable releases both the data bus and the interrupt pin.

Top module: `hostbus_regif`

## Requirements
- R1: With `moto_mode` low, a write is committed on the rising edge of `wr_n_rw` when `cs_n` was low just before that edge. The data and the effective address are the values present just before the edge, and the new value is readable within 4 clocks after the edge.
- R2: With `moto_mode` low, while `cs_n` and `rd_n_e` are both low, `bus_drive` is high and `bus_dout` carries the addressed register.
- R3: With `moto_mode` high, while `cs_n` is low and both `wr_n_rw` and `rd_n_e` are high, `bus_drive` is high and `bus_dout` carries the addressed register.
- R4: With `moto_mode` high, a write is committed on the falling edge of `rd_n_e` when `cs_n` and `wr_n_rw` were both low just before that edge. A falling `rd_n_e` edge with `wr_n_rw` high commits nothing, and neither does any `wr_n_rw` movement while `rd_n_e` is low.
- R5: The register map is as follows. Address 0x00 is the interrupt status register, write 1 to clear. Address 0x01 is the interrupt mask register, where 1 enables that bit. Addresses 0x04 to 0x07 are four read/write general registers. Every other address reads 0x00, and writes to it change nothing.
- R6: While `as_n` is high the address passes straight through. On the falling edge of `as_n` the address is frozen, and accesses made while `as_n` stays low use the frozen address.
- R7: A one-clock pulse on bit i of `irq_src` sets status bit i, which stays set until written with 1. If a source pulse and a clearing write fall in the same cycle, the set wins. `irq_pull` is high exactly when `status & mask` is non-zero.
- R8: While `out_en_n` is low, `bus_drive` and `irq_pull` are both low, whatever else is happening.
- R9: While `rst_n` is low, status, mask and general registers are 0x00, and `bus_drive` and `irq_pull` are low.
- R10: A write whose chip select is removed before its commit edge is dropped. A write strobe toggled while `cs_n` is high is also dropped.
- R11: Each qualifying edge produces exactly one single-cycle write pulse. `bus_drive` rises on the third clock edge after the read condition appears, and never during a write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset, asynchronous |
| moto_mode | input | 1 | 1 = enable-strobe protocol, 0 = split-strobe protocol |
| cs_n | input | 1 | Active-low chip select |
| as_n | input | 1 | Address strobe; high = pass-through, falling edge freezes address |
| rd_n_e | input | 1 | Read strobe (active low) or bus enable (active high) |
| wr_n_rw | input | 1 | Write strobe (active low) or read/write level (1 = read) |
| addr | input | ADDR_W | Register address |
| bus_din | input | DATA_W | Data bus, host to block |
| bus_dout | output | DATA_W | Data bus, block to host; 0 when not driving |
| bus_drive | output | 1 | 1 = block drives the data bus |
| out_en_n | input | 1 | Active-low output enable; low releases all outputs |
| irq_src | input | DATA_W | One-clock interrupt event pulses from internal sources |
| irq_pull | output | 1 | 1 = interrupt pin pulled low, 0 = released |

## Verification
A wrong access state shows up as a bus drive that is missing or out of time. It can also show up as a readback that differs from the value written, and that difference appears on the very next read of the affected address. A corrupted address latch or misaligned pipeline shows up the same way: the written value lands in the wrong register, and the full sweep of all 256 addresses in both protocols catches it as a non-zero read of an unmapped location or a stale mapped one. A status or mask fault shows on `irq_pull` within one clock of the source pulse or the write that should have changed it.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READ    = 2'd1,
        ST_WR_HOLD = 2'd2,
        ST_COMMIT  = 2'd3
    } hb_state_e;
endpackage

// File: rtl/hb_pipe.sv
// Reset-initialised shift pipeline; used as synchronizer and alignment delay.
module hb_pipe #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stg
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_addr_latch.sv
// Address pass-through / freeze for multiplexed buses.
module hb_addr_latch #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_s,      // synchronized address strobe
    input  logic [ADDR_W-1:0] addr_s,    // address aligned with as_s
    output logic [ADDR_W-1:0] eff_now,   // effective address, strobe-aligned
    output logic [ADDR_W-1:0] eff_dly    // one cycle later, edge-aligned
);
    logic [ADDR_W-1:0] held;

    // Tracks the bus while the strobe is high; the last high sample survives the fall.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    held <= '0;
        else if (as_s) held <= addr_s;
    end

    assign eff_now = as_s ? addr_s : held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eff_dly <= '0;
        else        eff_dly <= eff_now;
    end
endmodule

// File: rtl/hb_access_fsm.sv
// Access sequencer: turns synchronized strobes into a read window and a
// single-cycle write pulse, for either strobe protocol.
module hb_access_fsm
    import hb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              moto_s,
    input  logic              cs_s,       // synchronized chip select (active low)
    input  logic              stb_a_s,    // read strobe / enable
    input  logic              stb_b_s,    // write strobe / read-write level
    input  logic [ADDR_W-1:0] cap_addr,   // address aligned with previous strobe sample
    input  logic [DATA_W-1:0] cap_data,   // data aligned with previous strobe sample
    output logic              rd_active,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    hb_state_e state, nxt;
    logic      cs_d, a_d, b_d;
    logic      rd_lvl, wr_lvl, wr_edge;

    // Previous synchronized sample, for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d <= 1'b1;
            a_d  <= 1'b1;
            b_d  <= 1'b1;
        end else begin
            cs_d <= cs_s;
            a_d  <= stb_a_s;
            b_d  <= stb_b_s;
        end
    end

    // Protocol decode.
    always_comb begin
        if (moto_s) begin
            rd_lvl  = !cs_s && stb_b_s && stb_a_s;
            wr_lvl  = !cs_s && !stb_b_s && stb_a_s;
            wr_edge = !cs_d && !b_d && a_d && !stb_a_s;
        end else begin
            rd_lvl  = !cs_s && !stb_a_s;
            wr_lvl  = !cs_s && !stb_b_s;
            wr_edge = !cs_d && !b_d && stb_b_s;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_lvl)      nxt = ST_WR_HOLD;
                else if (rd_lvl) nxt = ST_READ;
            end
            ST_READ: begin
                if (!rd_lvl)     nxt = ST_IDLE;
            end
            ST_WR_HOLD: begin
                if (wr_edge)     nxt = ST_COMMIT;
                else if (!wr_lvl) nxt = ST_IDLE;
            end
            ST_COMMIT: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Payload captured at the qualifying edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (state == ST_WR_HOLD && wr_edge) begin
            wr_addr <= cap_addr;
            wr_data <= cap_data;
        end
    end

    // Outputs.
    always_comb begin
        rd_active = (state == ST_READ);
        wr_pulse  = (state == ST_COMMIT);
    end
endmodule

// File: rtl/hb_regbank.sv
// Status (write-1-clear), mask, and general registers; unmapped reads return zero.
module hb_regbank #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int NUM_GP      = 4,
    parameter int GP_BASE     = 4,
    parameter int STATUS_ADDR = 0,
    parameter int MASK_ADDR   = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [DATA_W-1:0]             irq_set,
    output logic [DATA_W-1:0]             rd_data,
    output logic [DATA_W-1:0]             status,
    output logic [DATA_W-1:0]             mask,
    output logic [NUM_GP-1:0][DATA_W-1:0] gp
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(MASK_ADDR);

    logic [DATA_W-1:0] gp_q [NUM_GP];
    logic [DATA_W-1:0] clr;

    assign clr = (wr_en && wr_addr == A_STATUS) ? wr_data : '0;

    // Set wins over a simultaneous clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | irq_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           mask <= '0;
        else if (wr_en && wr_addr == A_MASK)  mask <= wr_data;
    end

    generate
        for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
            localparam logic [ADDR_W-1:0] A_GP = ADDR_W'(GP_BASE + i);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                         gp_q[i] <= '0;
                else if (wr_en && wr_addr == A_GP)  gp_q[i] <= wr_data;
            end
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NUM_GP; i++) gp[i] = gp_q[i];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_STATUS)    rd_data = status;
        else if (rd_addr == A_MASK) rd_data = mask;
        for (int i = 0; i < NUM_GP; i++) begin
            if (rd_addr == ADDR_W'(GP_BASE + i)) rd_data = gp_q[i];
        end
    end
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int NUM_GP      = 4,
    parameter int GP_BASE     = 4,
    parameter int STATUS_ADDR = 0,
    parameter int MASK_ADDR   = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              moto_mode,
    input  logic              cs_n,
    input  logic              as_n,
    input  logic              rd_n_e,
    input  logic              wr_n_rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_drive,
    input  logic              out_en_n,
    input  logic [DATA_W-1:0] irq_src,
    output logic              irq_pull
);
    localparam int CTL_W       = 5;
    localparam int DATA_STAGES = SYNC_STAGES + 1;  // matches the edge-detect register

    logic [CTL_W-1:0]             ctl_q;
    logic                         moto_s, as_s, cs_s, a_s, b_s;
    logic [ADDR_W-1:0]            addr_s, eff_now, eff_dly;
    logic [DATA_W-1:0]            data_al;
    logic                         rd_active, wr_pulse;
    logic [ADDR_W-1:0]            wr_addr;
    logic [DATA_W-1:0]            wr_data;
    logic [DATA_W-1:0]            rd_data, status, mask;
    logic [NUM_GP-1:0][DATA_W-1:0] gp;

    hb_pipe #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b01111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({moto_mode, as_n, cs_n, rd_n_e, wr_n_rw}),
        .q(ctl_q)
    );
    assign {moto_s, as_s, cs_s, a_s, b_s} = ctl_q;

    hb_pipe #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_addr_pipe (
        .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_s)
    );

    hb_pipe #(.W(DATA_W), .STAGES(DATA_STAGES), .RST_VAL('0)) u_data_pipe (
        .clk(clk), .rst_n(rst_n), .d(bus_din), .q(data_al)
    );

    hb_addr_latch #(.ADDR_W(ADDR_W)) u_alat (
        .clk(clk), .rst_n(rst_n), .as_s(as_s), .addr_s(addr_s),
        .eff_now(eff_now), .eff_dly(eff_dly)
    );

    hb_access_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .moto_s(moto_s), .cs_s(cs_s),
        .stb_a_s(a_s), .stb_b_s(b_s),
        .cap_addr(eff_dly), .cap_data(data_al),
        .rd_active(rd_active), .wr_pulse(wr_pulse),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    hb_regbank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_GP(NUM_GP), .GP_BASE(GP_BASE),
        .STATUS_ADDR(STATUS_ADDR), .MASK_ADDR(MASK_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_pulse), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(eff_now), .irq_set(irq_src),
        .rd_data(rd_data), .status(status), .mask(mask), .gp(gp)
    );

    // Output enable overrides everything, asynchronously.
    assign bus_drive = rd_active && out_en_n;
    assign bus_dout  = bus_drive ? rd_data : '0;
    assign irq_pull  = (|(status & mask)) && out_en_n;
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int NUM_GP      = 4,
    parameter int GP_BASE     = 4,
    parameter int STATUS_ADDR = 0,
    parameter int MASK_ADDR   = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     out_en_n,
    input logic                     bus_drive,
    input logic                     irq_pull,
    input logic                     wr_pulse,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic [DATA_W-1:0]        status,
    input logic [DATA_W-1:0]        mask,
    input logic [NUM_GP*DATA_W-1:0] gp
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(MASK_ADDR);
    localparam logic [ADDR_W-1:0] GP_LO    = ADDR_W'(GP_BASE);
    localparam logic [ADDR_W-1:0] GP_HI    = ADDR_W'(GP_BASE + NUM_GP);

    logic wr_unmapped;
    assign wr_unmapped = (wr_addr != A_STATUS) && (wr_addr != A_MASK) &&
                         !((wr_addr >= GP_LO) && (wr_addr < GP_HI));

    p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    p_no_drive_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> !bus_drive);

    p_oe_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_n |-> (!bus_drive && !irq_pull));

    p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> ((status & $past(status)) == $past(status)));

    p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_addr == A_MASK) |=> (mask == $past(wr_data)));

    p_unmapped_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_unmapped) |=> ($stable(mask) && $stable(gp)));
endmodule

bind hostbus_regif hb_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_GP(NUM_GP), .GP_BASE(GP_BASE),
    .STATUS_ADDR(STATUS_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .bus_drive(bus_drive),
    .irq_pull(irq_pull), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_data(wr_data), .status(status), .mask(mask), .gp(gp)
);

// File: tb/tb_hostbus_regif.sv
module tb_hostbus_regif;
    logic       clk = 1'b0;
    logic       rst_n, moto_mode, cs_n, as_n, rd_n_e, wr_n_rw, out_en_n;
    logic [7:0] addr, bus_din, irq_src;
    logic [7:0] bus_dout;
    logic       bus_drive, irq_pull;

    int n_vec = 0;
    int n_bad = 0;

    logic [7:0] m_status, m_mask;
    logic [7:0] m_gp [4];

    always #2 clk = ~clk;

    hostbus_regif dut (
        .clk(clk), .rst_n(rst_n), .moto_mode(moto_mode), .cs_n(cs_n),
        .as_n(as_n), .rd_n_e(rd_n_e), .wr_n_rw(wr_n_rw), .addr(addr),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_drive(bus_drive),
        .out_en_n(out_en_n), .irq_src(irq_src), .irq_pull(irq_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'h00) return m_status;
        if (a == 8'h01) return m_mask;
        if (a >= 8'h04 && a <= 8'h07) return m_gp[a - 8'h04];
        return 8'h00;
    endfunction

    function automatic bit is_mapped(input logic [7:0] a);
        return (a <= 8'h01) || (a >= 8'h04 && a <= 8'h07);
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h00) m_status = m_status & ~d;
        else if (a == 8'h01) m_mask = d;
        else if (a >= 8'h04 && a <= 8'h07) m_gp[a - 8'h04] = d;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        addr = a; bus_din = d;
        if (!moto_mode) begin
            cs_n = 1'b0; tick(1);
            wr_n_rw = 1'b0; tick(4);
            wr_n_rw = 1'b1; tick(4);
            cs_n = 1'b1; tick(3);
        end else begin
            wr_n_rw = 1'b0; cs_n = 1'b0; tick(1);
            rd_n_e = 1'b1; tick(4);
            rd_n_e = 1'b0; tick(4);
            cs_n = 1'b1; wr_n_rw = 1'b1; tick(3);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        do_write(a, d);
        model_write(a, d);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] v, output logic drv);
        addr = a;
        if (!moto_mode) begin
            cs_n = 1'b0; rd_n_e = 1'b0; tick(5);
            v = bus_dout; drv = bus_drive;
            rd_n_e = 1'b1; cs_n = 1'b1; tick(4);
        end else begin
            wr_n_rw = 1'b1; cs_n = 1'b0; rd_n_e = 1'b1; tick(5);
            v = bus_dout; drv = bus_drive;
            rd_n_e = 1'b0; cs_n = 1'b1; tick(4);
        end
    endtask

    task automatic pulse_src(input logic [7:0] s);
        irq_src = s; tick(1);
        irq_src = 8'h00; tick(1);
        m_status = m_status | s;
    endtask

    task automatic sweep(input string t_map, input string t_drv);
        logic [7:0] v;
        logic       drv;
        for (int a = 0; a < 256; a++) begin
            if (!moto_mode) wr(8'(a), 8'((a * 7 + 3) & 255));
            else            wr(8'(a), 8'(a) ^ 8'hA5);
        end
        for (int a = 0; a < 256; a++) begin
            do_read(8'(a), v, drv);
            chk(is_mapped(8'(a)) ? t_map : "R5 unmapped reads zero", v, model_read(8'(a)));
            chk(t_drv, {7'd0, drv}, 8'h01);
        end
    endtask

    initial begin
        logic [7:0] v;
        logic       drv;
        rst_n = 1'b0; moto_mode = 1'b0; cs_n = 1'b1; as_n = 1'b1;
        rd_n_e = 1'b1; wr_n_rw = 1'b1; addr = 8'h00; bus_din = 8'h00;
        out_en_n = 1'b1; irq_src = 8'h00;
        m_status = 8'h00; m_mask = 8'h00;
        for (int i = 0; i < 4; i++) m_gp[i] = 8'h00;
        tick(4);
        chk("R9 drive in reset", {7'd0, bus_drive}, 8'h00);
        chk("R9 irq in reset", {7'd0, irq_pull}, 8'h00);
        rst_n = 1'b1; tick(4);

        // R9 defaults after reset
        do_read(8'h01, v, drv); chk("R9 mask default", v, 8'h00);
        do_read(8'h04, v, drv); chk("R9 gp default", v, 8'h00);
        do_read(8'h00, v, drv); chk("R9 status default", v, 8'h00);

        // R11 read drive latency
        addr = 8'h01; cs_n = 1'b0; rd_n_e = 1'b0;
        tick(2); chk("R11 drive not before third edge", {7'd0, bus_drive}, 8'h00);
        tick(1); chk("R11 drive at third edge", {7'd0, bus_drive}, 8'h01);
        rd_n_e = 1'b1; cs_n = 1'b1; tick(4);
        chk("R2 drive released", {7'd0, bus_drive}, 8'h00);

        // R1/R2/R5 split-strobe sweep
        sweep("R1 split-strobe readback", "R2 split-strobe drive");

        // R10 abort and chip-select-high writes
        addr = 8'h04; bus_din = 8'hAB; cs_n = 1'b0; tick(1);
        wr_n_rw = 1'b0; tick(4); cs_n = 1'b1; tick(4); wr_n_rw = 1'b1; tick(4);
        do_read(8'h04, v, drv); chk("R10 aborted write dropped", v, m_gp[0]);
        addr = 8'h04; bus_din = 8'hCD;
        wr_n_rw = 1'b0; tick(4); wr_n_rw = 1'b1; tick(4);
        do_read(8'h04, v, drv); chk("R10 write with cs high dropped", v, m_gp[0]);

        // R6 multiplexed address latch
        addr = 8'h05; tick(1); as_n = 1'b0; tick(4);
        do_write(8'hEE, 8'h77); model_write(8'h05, 8'h77);
        do_read(8'hC3, v, drv); chk("R6 frozen address used", v, 8'h77);
        as_n = 1'b1; tick(4);
        do_read(8'h05, v, drv); chk("R6 pass-through read", v, 8'h77);
        do_read(8'hEE, v, drv); chk("R6 noise address untouched", v, 8'h00);

        // R7/R8 interrupts
        wr(8'h01, 8'h00);
        pulse_src(8'h08);
        chk("R7 masked source silent", {7'd0, irq_pull}, 8'h00);
        do_read(8'h00, v, drv); chk("R7 status sticky", v, 8'h08);
        wr(8'h01, 8'h08);
        chk("R7 enabled source pulls", {7'd0, irq_pull}, 8'h01);
        pulse_src(8'h01);
        do_read(8'h00, v, drv); chk("R7 status accumulates", v, 8'h09);
        out_en_n = 1'b0; tick(1);
        chk("R8 irq released", {7'd0, irq_pull}, 8'h00);
        do_read(8'h00, v, drv);
        chk("R8 bus released", {7'd0, drv}, 8'h00);
        chk("R8 dout idle", v, 8'h00);
        out_en_n = 1'b1; tick(1);
        chk("R8 irq returns", {7'd0, irq_pull}, 8'h01);
        wr(8'h00, 8'h08);
        do_read(8'h00, v, drv); chk("R5 write-one clears", v, m_status);
        chk("R7 cleared bit drops irq", {7'd0, irq_pull}, 8'h00);
        wr(8'h01, 8'h01);
        chk("R7 other bit enabled", {7'd0, irq_pull}, 8'h01);
        wr(8'h00, 8'hFF);
        chk("R7 all cleared", {7'd0, irq_pull}, 8'h00);
        do_read(8'h00, v, drv); chk("R5 status empty", v, 8'h00);

        // Switch protocol
        cs_n = 1'b1; rd_n_e = 1'b0; wr_n_rw = 1'b1; moto_mode = 1'b1; tick(4);

        // R3/R4/R5 enable-strobe sweep
        sweep("R4 enable-strobe readback", "R3 enable-strobe drive");

        // R4 non-writes
        addr = 8'h06; bus_din = 8'h3C; wr_n_rw = 1'b1; cs_n = 1'b0; tick(1);
        rd_n_e = 1'b1; tick(4); rd_n_e = 1'b0; tick(4); cs_n = 1'b1; tick(3);
        do_read(8'h06, v, drv); chk("R4 enable fall with read level", v, m_gp[2]);
        addr = 8'h06; bus_din = 8'h5E; cs_n = 1'b0; tick(1);
        wr_n_rw = 1'b0; tick(4); wr_n_rw = 1'b1; tick(4); cs_n = 1'b1; tick(3);
        do_read(8'h06, v, drv); chk("R4 rw toggle without enable", v, m_gp[2]);

        // R9 reset mid-run
        wr(8'h01, 8'h02);
        pulse_src(8'h02);
        chk("R7 pull before reset", {7'd0, irq_pull}, 8'h01);
        rst_n = 1'b0; tick(2);
        chk("R9 irq cleared by reset", {7'd0, irq_pull}, 8'h00);
        rst_n = 1'b1; tick(4);
        m_status = 8'h00; m_mask = 8'h00;
        for (int i = 0; i < 4; i++) m_gp[i] = 8'h00;
        do_read(8'h01, v, drv); chk("R9 mask reset", v, 8'h00);
        do_read(8'h06, v, drv); chk("R9 gp reset", v, 8'h00);
        do_read(8'h00, v, drv); chk("R9 status reset", v, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule